// File: doc/BRIEF.md
# Scanline Playfield Bit Serializer

This block turns a 20-bit background pattern into a one-bit pixel stream, one scanline at a time. Software loads the pattern through a small synchronous write port. The pattern is split over three storage banks: a 4-bit bank and two 8-bit banks. A scanline runs for 228 colour clocks. The caller supplies the current colour-clock position, and the block drives a single "playfield on" bit for that position.

Each pattern bit covers four colour clocks, which gives 40 coarse pixels across the 160 visible positions. The 20 bits fill the left half of the line and are then shown again on the right half. A control bit chooses whether the right half repeats the left-half order or runs it backwards. Stored values take effect on the next clock. Software can therefore rewrite a bank after its left-half pixels have been shown and before its right-half pixels begin, which gives a line with different left and right halves.

Top module: `pf_line_serializer`

## Requirements
- R1: After reset all three banks and the mirror control read as zero, so `pf_bit` is 0 at every position of the line.
- R2: `pf_bit` is 0 whenever `hpos` is below 68 (retrace) or above 227.
- R3: Within the visible area, each pattern bit holds `pf_bit` steady for exactly four colour clocks, and these groups are aligned so that one starts at position 68.
- R4: Left half order: bank 0 bits 4,5,6,7 at positions 68–83, bank 1 bits 7 down to 0 at positions 84–115, and bank 2 bits 0 up to 7 at positions 116–147.
- R5: With mirror control 0, positions 148–227 show the same 20-bit order as the left half, starting with bank 0 bit 4 at position 148.
- R6: With mirror control 1, positions 148–227 show the left-half order reversed: bank 2 bit 7 at 148–151, and so on, ending with bank 0 bit 4 at 224–227.
- R7: Bits 3:0 of a write to bank 0 are discarded and never affect `pf_bit`.
- R8: A write accepted at a clock edge changes `pf_bit` from the following cycle onward, including in the middle of a line.
- R9: Write addresses are decoded as 0 = bank 0, 1 = bank 1, 2 = bank 2 and 3 = control, whose bit 0 is the mirror select. A write to any address from 4 to 7 changes nothing.
- R10: Stored values persist across any number of lines until they are written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hpos | input | 8 | Colour-clock position in the line, 0–227 |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| pf_bit | output | 1 | Playfield pixel for the current position |

## Verification
Full-line sweeps are run with sparse asymmetric patterns and with walking single bits, in repeat mode and then in mirror mode. A misplaced bank boundary, a reversed bit order inside a bank, or a wrong mirror start point each moves a lit pixel to a position the model does not predict. Directed writes issued partway through a line, with data whose low nibble differs, or aimed at unused addresses, separate correct immediate update from update that is delayed, dropped or wrongly decoded. Random lines with random writes scattered across each line then mix all of these cases with the mirror bit changing in the middle of a line.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int unsigned PF_HALF_BITS = 20;
  localparam int unsigned PF_B0_W      = 4;
  localparam int unsigned PF_BANK_W    = 8;

  typedef enum logic [2:0] {
    PF_A_BANK0 = 3'd0,
    PF_A_BANK1 = 3'd1,
    PF_A_BANK2 = 3'd2,
    PF_A_CTRL  = 3'd3
  } pf_addr_e;

  typedef struct packed {
    logic [PF_B0_W-1:0]   bank0;
    logic [PF_BANK_W-1:0] bank1;
    logic [PF_BANK_W-1:0] bank2;
    logic                 mirror;
  } pf_state_t;

endpackage

// File: rtl/pf_regs.sv
module pf_regs
  import pf_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [PF_HALF_BITS-1:0] seq,
  output logic                    mirror
);

  localparam int unsigned B0_LSB = DATA_W - PF_B0_W;
  localparam int unsigned B1_OFF = PF_B0_W;
  localparam int unsigned B2_OFF = PF_B0_W + PF_BANK_W;

  pf_state_t state_q;
  pf_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_W'(PF_A_BANK0): state_d.bank0  = wr_data[DATA_W-1:B0_LSB];
        ADDR_W'(PF_A_BANK1): state_d.bank1  = wr_data[PF_BANK_W-1:0];
        ADDR_W'(PF_A_BANK2): state_d.bank2  = wr_data[PF_BANK_W-1:0];
        ADDR_W'(PF_A_CTRL):  state_d.mirror = wr_data[0];
        default:             state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (wr_en) begin
      state_q <= state_d;
    end
  end

  // Flatten the banks into left-half display order
  for (genvar g = 0; g < PF_B0_W; g++) begin : g_b0
    assign seq[g] = state_q.bank0[g];
  end
  for (genvar g = 0; g < PF_BANK_W; g++) begin : g_b12
    assign seq[B1_OFF + g] = state_q.bank1[PF_BANK_W-1-g];
    assign seq[B2_OFF + g] = state_q.bank2[g];
  end

  assign mirror = state_q.mirror;

endmodule

// File: rtl/pf_index.sv
module pf_index #(
  parameter int unsigned POS_W     = 8,
  parameter int unsigned LINE_CLKS = 228,
  parameter int unsigned HBLANK    = 68,
  parameter int unsigned PIX_CLKS  = 4,
  parameter int unsigned HALF_PIX  = 20
) (
  input  logic [POS_W-1:0] hpos,
  input  logic             mirror,
  output logic             vis,
  output logic [POS_W-1:0] idx
);

  localparam logic [POS_W-1:0] P_HBLANK = POS_W'(HBLANK);
  localparam logic [POS_W-1:0] P_LINE   = POS_W'(LINE_CLKS);
  localparam logic [POS_W-1:0] P_PIX    = POS_W'(PIX_CLKS);
  localparam logic [POS_W-1:0] P_HALF   = POS_W'(HALF_PIX);
  localparam logic [POS_W-1:0] P_LAST   = POS_W'(HALF_PIX - 1);

  logic [POS_W-1:0] rel;
  logic [POS_W-1:0] pix;
  logic [POS_W-1:0] col;
  logic             right;

  always_comb begin
    vis   = (hpos >= P_HBLANK) && (hpos < P_LINE);
    rel   = hpos - P_HBLANK;
    pix   = rel / P_PIX;
    right = (pix >= P_HALF);
    col   = right ? (pix - P_HALF) : pix;
    idx   = (right && mirror) ? (P_LAST - col) : col;
  end

endmodule

// File: rtl/pf_select.sv
module pf_select
  import pf_pkg::*;
#(
  parameter int unsigned POS_W = 8
) (
  input  logic [PF_HALF_BITS-1:0] seq,
  input  logic                    vis,
  input  logic [POS_W-1:0]        idx,
  output logic                    pf_bit
);

  localparam int unsigned IDX_W = $clog2(PF_HALF_BITS);

  always_comb begin
    pf_bit = 1'b0;
    if (vis && (idx < POS_W'(PF_HALF_BITS))) begin
      pf_bit = seq[idx[IDX_W-1:0]];
    end
  end

endmodule

// File: rtl/pf_line_serializer.sv
module pf_line_serializer
  import pf_pkg::*;
#(
  parameter int unsigned POS_W     = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LINE_CLKS = 228,
  parameter int unsigned HBLANK    = 68,
  parameter int unsigned PIX_CLKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  hpos,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pf_bit
);

  logic [1:0]              rst_sync_q;
  logic                    rst_core_n;
  logic [PF_HALF_BITS-1:0] pf_seq;
  logic                    mirror_q;
  logic                    vis;
  logic [POS_W-1:0]        idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  pf_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .seq     (pf_seq),
    .mirror  (mirror_q)
  );

  pf_index #(
    .POS_W     (POS_W),
    .LINE_CLKS (LINE_CLKS),
    .HBLANK    (HBLANK),
    .PIX_CLKS  (PIX_CLKS),
    .HALF_PIX  (PF_HALF_BITS)
  ) u_index (
    .hpos   (hpos),
    .mirror (mirror_q),
    .vis    (vis),
    .idx    (idx)
  );

  pf_select #(
    .POS_W (POS_W)
  ) u_select (
    .seq    (pf_seq),
    .vis    (vis),
    .idx    (idx),
    .pf_bit (pf_bit)
  );

endmodule

// File: rtl/pf_line_serializer_chk.sv
module pf_line_serializer_chk #(
  parameter int unsigned POS_W  = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [POS_W-1:0]  hpos,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pf_bit,
  input logic [19:0]       pf_seq,
  input logic              mirror_q
);

  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos < POS_W'(68)) |-> !pf_bit); // R2

  AST_PAST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos > POS_W'(227)) |-> !pf_bit); // R2

  AST_PIXEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((hpos > POS_W'(68)) && (hpos <= POS_W'(227)) &&
     (((hpos - POS_W'(68)) % POS_W'(4)) != '0) &&
     ($past(hpos) == hpos - POS_W'(1)) && !$past(wr_en))
    |-> (pf_bit == $past(pf_bit))); // R3

  AST_BANK0_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(0)))
    |=> (pf_seq[3:0] == $past(wr_data[7:4]))); // R7

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(3)))
    |=> (mirror_q == $past(wr_data[0]))); // R6

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= ADDR_W'(4)))
    |=> ($stable(pf_seq) && $stable(mirror_q))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pf_seq) && $stable(mirror_q))); // R10

endmodule

bind pf_line_serializer pf_line_serializer_chk #(
  .POS_W  (POS_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hpos     (hpos),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .pf_bit   (pf_bit),
  .pf_seq   (pf_seq),
  .mirror_q (mirror_q)
);

// File: tb/tb_pf_line_serializer.sv
`timescale 1ns/1ps
module tb_pf_line_serializer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hpos;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       pf_bit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // shadow of the stored pattern, kept from the requirements
  logic [7:0] sh0, sh1, sh2;
  logic       shm;

  always #5 clk = ~clk;

  pf_line_serializer dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .hpos    (hpos),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pf_bit  (pf_bit)
  );

  // R4 display order of left-half bit k (0..19)
  function automatic logic seq_bit(input int k);
    if (k < 4)       return sh0[4 + k];
    else if (k < 12) return sh1[11 - k];
    else             return sh2[k - 12];
  endfunction

  // R2, R3, R5, R6 expected pixel for position h
  function automatic logic exp_bit(input int h);
    int p, j;
    if (h < 68 || h > 227) return 1'b0;
    p = (h - 68) / 4;
    j = p % 20;
    if (p >= 20 && shm) j = 19 - j;
    return seq_bit(j);
  endfunction

  // R9 decode, R7 low nibble dropped
  task automatic shadow_write(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: sh0 = {d[7:4], 4'h0};
      3'd1: sh1 = d;
      3'd2: sh2 = d;
      3'd3: shm = d[0];
      default: ;
    endcase
  endtask

  task automatic check(input logic act, input logic exp, input string req, input int h);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s hpos=%0d actual=%0b expected=%0b", req, h, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hpos = 8'd0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    shadow_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one full line; optional write during position wr_at (R8)
  task automatic run_line(input int wr_at, input logic [2:0] a, input logic [7:0] d,
                          input string req);
    for (int h = 0; h < 228; h++) begin
      @(negedge clk);
      hpos = 8'(h); wr_en = (h == wr_at); wr_addr = a; wr_data = d;
      #1;
      check(pf_bit, exp_bit(h), req, h);
      if (h == wr_at) shadow_write(a, d);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rand_line();
    for (int h = 0; h < 228; h++) begin
      @(negedge clk);
      hpos = 8'(h);
      wr_en = (($urandom % 12) == 0);
      wr_addr = 3'($urandom);
      wr_data = 8'($urandom);
      #1;
      check(pf_bit, exp_bit(h), "R8 random", h);
      if (wr_en) shadow_write(wr_addr, wr_data);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    sh0 = '0; sh1 = '0; sh2 = '0; shm = 1'b0;
    rst_n = 1'b0; hpos = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state across a whole line
    run_line(-1, 3'd0, 8'h00, "R1");

    // R4 / R5 asymmetric pattern, repeat mode
    do_write(3'd0, 8'hA5);
    do_write(3'd1, 8'hC3);
    do_write(3'd2, 8'h5E);
    do_write(3'd3, 8'h00);
    run_line(-1, 3'd0, 8'h00, "R4 R5");

    // R6 mirror mode
    do_write(3'd3, 8'h01);
    run_line(-1, 3'd0, 8'h00, "R6");

    // R6 corner: single bank2 bits, mirror start/end
    do_write(3'd0, 8'h10);
    do_write(3'd1, 8'h00);
    do_write(3'd2, 8'h81);
    run_line(-1, 3'd0, 8'h00, "R6 walk");

    // R7 low nibble discarded
    do_write(3'd0, 8'h0F);
    run_line(-1, 3'd0, 8'h00, "R7");

    // R9 unused address mid-line
    run_line(150, 3'd5, 8'hFF, "R9");
    run_line(-1, 3'd0, 8'h00, "R9 after");

    // R8 mid-line rewrite of bank1 and bank0 between halves, repeat mode
    do_write(3'd3, 8'h00);
    do_write(3'd1, 8'h0F);
    run_line(120, 3'd1, 8'hF0, "R8 bank1");
    run_line(100, 3'd0, 8'h90, "R8 bank0");
    run_line(160, 3'd3, 8'h01, "R8 mirror");

    // R10 persistence across idle lines
    for (int n = 0; n < 3; n++) run_line(-1, 3'd0, 8'h00, "R10");

    // R3 walking single bits over each bank position
    for (int b = 0; b < 8; b++) begin
      do_write(3'd1, 8'(1 << b));
      do_write(3'd2, 8'(8'h80 >> b));
      run_line(-1, 3'd0, 8'h00, "R3 walk");
    end

    for (int n = 0; n < 30; n++) rand_line();

    finish_run();
  end

endmodule